// File: doc/BRIEF.md
# Enable-Masked Channel Sample Packer

The packer sits between a multi-channel sample source and a single wide write port. All channels share one write strobe, and a per-channel enable mask chooses which channels carry live samples. On every write beat the block drops the samples of disabled channels and closes up the gaps between the rest. It appends those samples to an internal accumulator. When the accumulator holds enough samples to fill every lane of the output word, it emits that word with a one-cycle valid pulse.

Each channel may carry several samples per beat. The inputs are grouped by channel. Before packing, the block rewires them into sample-major order, so that all channels' first samples come before all channels' second samples. A channel count that is not a power of two is padded up to the next power of two. The padding channels are always disabled and fed zeros.

The block applies no backpressure. The consumer must take each word in the cycle its valid pulse is high, or the word is lost. An overflow flag from the downstream sink is passed straight back to the source. A sync marker flags the first word emitted after reset. The enable mask is captured once after reset, so a new mask takes effect only through a reset.

Top module: `chan_packer`

## Requirements
- R1: While reset is asserted, `pk_vld` and `pk_sync` are 0.
- R2: Samples are taken only on cycles with `wr_en` high. Only channels whose enable bit is 1 contribute. The data on disabled channels, and on any channel in a cycle without `wr_en`, never reaches `pk_data`.
- R3: Accepted samples form one sequence. Within a beat they are ordered by sample slot first (slot 0 of every channel, then slot 1, …). Within a slot they are ordered by ascending channel index. Successive beats follow in time order. Lane i (bits `[8i+7:8i]` for 8-bit samples) of the w-th emitted word carries sample number w·LANES + i of that sequence.
- R4: `pk_vld` is a one-cycle pulse. It is high in the cycle after a write beat whose samples bring the accumulated count to LANES or more, and low otherwise. Idle cycles between beats neither emit a word nor lose stored samples.
- R5: `pk_data` is registered and changes only when a word is emitted.
- R6: `up_overflow` equals `dn_overflow` in the same cycle, with no register in between.
- R7: `pk_data` has one lane per sample slot of each channel of the padded (power-of-two) channel count. Padding channels never contribute samples.
- R8: `pk_sync` is high together with the first word emitted after reset, and low for every later word.
- R9: The enable mask is captured on the first clock after reset release. Later changes to `ch_en` are ignored until the next reset.
- R10: With a power-of-two channel count and every channel enabled, each write beat produces a word in the next cycle, and that word equals the sample-major reordering of the beat's input.
- R11: With an all-zero enable mask, no word is ever emitted.
- R12: Reset discards any partially accumulated samples. The first word after reset starts again at sequence number 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_en | input | NUM_CH | Per-channel enable mask, captured after reset |
| wr_en | input | 1 | Shared write strobe for all channels |
| ch_data | input | NUM_CH·SMP·SMP_W | Channel-grouped input samples; channel c, slot h at lane c·SMP+h |
| dn_overflow | input | 1 | Overflow flag from the downstream sink |
| up_overflow | output | 1 | Copy of `dn_overflow` for the source |
| pk_vld | output | 1 | One-cycle pulse marking a valid packed word |
| pk_sync | output | 1 | Marks the first packed word after reset |
| pk_data | output | CH_P2·SMP·SMP_W | Packed output word, meaningful only while `pk_vld` is high |

## Verification
Suppose the fill count or the merge offset goes wrong. Then the next emitted word shows a lane holding a repeated, skipped or foreign sample number, or a valid pulse arrives one beat early or late. Because every accepted sample is numbered in sequence, a single misplaced sample shows up in the very next word. If the mask register fails to hold after capture, the sequence numbers break at the first word after the mask pins change. If the first-word flag is wrong, the sync marker is missing on word 0 or appears again on a later word.

// File: rtl/chan_pack_pkg.sv
`timescale 1ns/1ps
package chan_pack_pkg;

  // Smallest power of two not below n (n >= 1).
  function automatic int pow2_ceil(input int n);
    int p;
    p = 1;
    for (int i = 0; i < 31; i++) begin
      if (p < n) p = p * 2;
    end
    return p;
  endfunction

  // Bits needed to count 0..n inclusive.
  function automatic int count_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/chan_shuffle.sv
`timescale 1ns/1ps
// Pure wiring: channel-grouped input to sample-major lanes, padding
// channels tied to zero and their lane enables held low.
module chan_shuffle #(
  parameter int NUM_CH = 3,
  parameter int CH_P2  = 4,
  parameter int SMP    = 2,
  parameter int SMP_W  = 8,
  localparam int IN_W  = NUM_CH * SMP * SMP_W,
  localparam int LANES = CH_P2 * SMP,
  localparam int OUT_W = LANES * SMP_W
) (
  input  logic [IN_W-1:0]  grp_data,
  input  logic [CH_P2-1:0] ch_mask,
  output logic [OUT_W-1:0] lane_data,
  output logic [LANES-1:0] lane_en
);

  for (genvar h = 0; h < SMP; h++) begin : g_slot
    for (genvar c = 0; c < CH_P2; c++) begin : g_ch
      localparam int DST = h * CH_P2 + c;
      assign lane_en[DST] = ch_mask[c];
      if (c < NUM_CH) begin : g_real
        assign lane_data[DST*SMP_W +: SMP_W] = grp_data[(c*SMP + h)*SMP_W +: SMP_W];
      end else begin : g_pad
        assign lane_data[DST*SMP_W +: SMP_W] = '0;
      end
    end
  end

endmodule

// File: rtl/lane_compactor.sv
`timescale 1ns/1ps
// Moves enabled lanes down to the low end, keeping their order, and
// reports how many there are.
module lane_compactor #(
  parameter int LANES = 8,
  parameter int SMP_W = 8,
  localparam int DW   = LANES * SMP_W,
  localparam int CW   = chan_pack_pkg::count_bits(LANES)
) (
  input  logic [DW-1:0]    lane_data,
  input  logic [LANES-1:0] lane_en,
  output logic [DW-1:0]    dense_data,
  output logic [CW-1:0]    dense_cnt
);

  always_comb begin
    int pos;
    pos        = 0;
    dense_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) begin
        dense_data[pos*SMP_W +: SMP_W] = lane_data[i*SMP_W +: SMP_W];
        pos = pos + 1;
      end
    end
    dense_cnt = CW'(pos);
  end

endmodule

// File: rtl/pack_accum.sv
`timescale 1ns/1ps
// Accumulates dense sample groups and emits full words.
module pack_accum #(
  parameter int LANES = 8,
  parameter int SMP_W = 8,
  localparam int DW   = LANES * SMP_W,
  localparam int CW   = chan_pack_pkg::count_bits(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_in,
  input  logic [DW-1:0] dense_data,
  input  logic [CW-1:0] dense_cnt,
  output logic          word_vld,
  output logic          word_sync,
  output logic [DW-1:0] word_data
);

  localparam logic [CW:0] LANES_V = (CW+1)'(LANES);

  logic [DW-1:0]   acc_q, acc_d;
  logic [CW-1:0]   fill_q, fill_d;
  logic            vld_q, vld_d;
  logic            sync_q, sync_d;
  logic            first_q, first_d;
  logic [DW-1:0]   dout_q, dout_d;
  logic [2*DW-1:0] merged;
  logic [CW:0]     sum;
  logic            full;

  // Place the new samples directly above the stored ones.
  always_comb begin
    merged = '0;
    for (int j = 0; j < 2 * LANES; j++) begin
      if (j < int'(fill_q)) begin
        merged[j*SMP_W +: SMP_W] = acc_q[j*SMP_W +: SMP_W];
      end else if ((j - int'(fill_q)) < int'(dense_cnt)) begin
        merged[j*SMP_W +: SMP_W] = dense_data[(j - int'(fill_q))*SMP_W +: SMP_W];
      end
    end
  end

  assign sum  = {1'b0, fill_q} + {1'b0, dense_cnt};
  assign full = (sum >= LANES_V);

  always_comb begin
    acc_d   = acc_q;
    fill_d  = fill_q;
    dout_d  = dout_q;
    first_d = first_q;
    vld_d   = 1'b0;
    sync_d  = 1'b0;
    if (wr_in) begin
      if (full) begin
        dout_d  = merged[DW-1:0];
        acc_d   = merged[2*DW-1:DW];
        fill_d  = CW'(sum - LANES_V);
        vld_d   = 1'b1;
        sync_d  = first_q;
        first_d = 1'b0;
      end else begin
        acc_d  = merged[DW-1:0];
        fill_d = sum[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      fill_q  <= '0;
      dout_q  <= '0;
      first_q <= 1'b1;
      vld_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      sync_q <= sync_d;
      if (wr_in) begin
        acc_q   <= acc_d;
        fill_q  <= fill_d;
        first_q <= first_d;
      end
      if (wr_in && full) begin
        dout_q <= dout_d;
      end
    end
  end

  assign word_vld  = vld_q;
  assign word_sync = sync_q;
  assign word_data = dout_q;

  assert_pulse_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(wr_in));
  assert_idle_keeps_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_in |=> $stable(fill_q) && !vld_q);
  assert_data_held_between_words_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(dout_q));
  assert_sync_rides_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> vld_q);
  assert_sync_only_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !first_q);

endmodule

// File: rtl/chan_packer.sv
`timescale 1ns/1ps
module chan_packer #(
  parameter int  NUM_CH = 4,
  parameter int  SMP    = 1,
  parameter int  SMP_W  = 16,
  localparam int CH_P2  = chan_pack_pkg::pow2_ceil(NUM_CH),
  localparam int LANES  = CH_P2 * SMP,
  localparam int IN_W   = NUM_CH * SMP * SMP_W,
  localparam int OUT_W  = LANES * SMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              wr_en,
  input  logic [IN_W-1:0]   ch_data,
  input  logic              dn_overflow,
  output logic              up_overflow,
  output logic              pk_vld,
  output logic              pk_sync,
  output logic [OUT_W-1:0]  pk_data
);

  localparam int CW = chan_pack_pkg::count_bits(LANES);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             cap_q, cap_d;
  logic [CH_P2-1:0] en_pad, en_q, en_d, mask_eff;
  logic [OUT_W-1:0] lane_data, dense_data;
  logic [LANES-1:0] lane_en;
  logic [CW-1:0]    dense_cnt;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    en_pad             = '0;
    en_pad[NUM_CH-1:0] = ch_en;
  end

  // Mask capture on the first working clock.
  always_comb begin
    cap_d = 1'b1;
    en_d  = cap_q ? en_q : en_pad;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_q <= 1'b0;
      en_q  <= '0;
    end else begin
      cap_q <= cap_d;
      if (!cap_q) en_q <= en_d;
    end
  end

  assign mask_eff = cap_q ? en_q : en_pad;

  chan_shuffle #(
    .NUM_CH(NUM_CH), .CH_P2(CH_P2), .SMP(SMP), .SMP_W(SMP_W)
  ) u_shuffle (
    .grp_data (ch_data),
    .ch_mask  (mask_eff),
    .lane_data(lane_data),
    .lane_en  (lane_en)
  );

  lane_compactor #(.LANES(LANES), .SMP_W(SMP_W)) u_compact (
    .lane_data (lane_data),
    .lane_en   (lane_en),
    .dense_data(dense_data),
    .dense_cnt (dense_cnt)
  );

  pack_accum #(.LANES(LANES), .SMP_W(SMP_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_in     (wr_en),
    .dense_data(dense_data),
    .dense_cnt (dense_cnt),
    .word_vld  (pk_vld),
    .word_sync (pk_sync),
    .word_data (pk_data)
  );

  assign up_overflow = dn_overflow;

  assert_mask_frozen_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_q |=> $stable(en_q));
  assert_full_mask_every_beat_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_eff == {CH_P2{1'b1}} && wr_en) |=> pk_vld);
  assert_empty_mask_silent_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_q && en_q == '0) |-> !pk_vld);
  assert_pad_lanes_off_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dense_cnt <= CW'($countones(en_pad[NUM_CH-1:0]) * SMP) || cap_q);

endmodule

// File: tb/chan_packer_bench.sv
`timescale 1ns/1ps
module chan_packer_bench;

  localparam int NC = 3, S = 2, W = 8, L = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ch_en = '0;
  logic        wr_en = 1'b0;
  logic [47:0] ch_data = '0;
  logic        dn_ovf = 1'b0;
  logic        up_ovf, pk_vld, pk_sync;
  logic [63:0] pk_data;

  logic [3:0]  p2_en = 4'hF;
  logic        p2_wr = 1'b0;
  logic [31:0] p2_din = '0;
  logic        p2_ovf_out, p2_vld, p2_sync;
  logic [31:0] p2_dout;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chan_packer #(.NUM_CH(NC), .SMP(S), .SMP_W(W)) u_chan_packer (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .wr_en(wr_en), .ch_data(ch_data),
    .dn_overflow(dn_ovf), .up_overflow(up_ovf), .pk_vld(pk_vld),
    .pk_sync(pk_sync), .pk_data(pk_data));

  chan_packer #(.NUM_CH(4), .SMP(1), .SMP_W(8)) u_chan_packer_p2 (
    .clk(clk), .rst_n(rst_n), .ch_en(p2_en), .wr_en(p2_wr), .ch_data(p2_din),
    .dn_overflow(1'b0), .up_overflow(p2_ovf_out), .pk_vld(p2_vld),
    .pk_sync(p2_sync), .pk_data(p2_dout));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply_reset(input logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0; ch_en = m; wr_en = 1'b0; p2_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(pk_vld == 1'b0, "R1 vld in reset", pk_vld, 0);
    check(pk_sync == 1'b0, "R1 sync in reset", pk_sync, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Exhaustive mask sweep on the padded, two-slot configuration.
    for (int m = 0; m < 8; m++) begin
      int tot, seq, k;
      apply_reset(3'(m));
      tot = 0; seq = 0;
      k = $countones(3'(m)) * S;
      for (int b = 0; b < 23; b++) begin
        bit w, emit;
        int newtot, word;
        w = (b % 3) != 2;
        wr_en = w;
        if (b == 6) ch_en = ~3'(m); // R9: late change must be ignored
        dn_ovf = b[0];
        for (int h = 0; h < S; h++) begin
          for (int c = 0; c < NC; c++) begin
            if (w && m[c]) begin
              ch_data[(c*S + h)*W +: W] = 8'(seq);
              seq++;
            end else begin
              ch_data[(c*S + h)*W +: W] = 8'($urandom);
            end
          end
        end
        #1;
        check(up_ovf == dn_ovf, "R6 overflow copy", up_ovf, dn_ovf);
        @(negedge clk);
        newtot = w ? tot + k : tot;
        emit = (newtot / L) > (tot / L);
        check(pk_vld == emit, (m == 0) ? "R11 no word" : "R4/R9 pulse", pk_vld, emit);
        if (emit) begin
          word = newtot / L - 1;
          for (int i = 0; i < L; i++) begin
            check(pk_data[i*W +: W] == 8'(word*L + i),
                  (word == 0) ? "R12 R3 restart" : ((m == 7) ? "R7 R2 R3 lane" : "R2 R3 lane"),
                  pk_data[i*W +: W], 8'(word*L + i));
          end
          check(pk_sync == (word == 0), "R8 sync", pk_sync, (word == 0));
        end
        tot = newtot;
      end
      // Idle gap: stored samples survive and no word appears (R4, R5).
      begin
        logic [63:0] held;
        held = pk_data;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        check(pk_vld == 1'b0, "R4 idle", pk_vld, 0);
        check(pk_data == held, "R5 data held", pk_data, held);
      end
    end

    // Full mask on a power-of-two channel count: one word per beat.
    apply_reset(3'b000);
    for (int b = 0; b < 10; b++) begin
      logic [31:0] d;
      d = $urandom;
      p2_wr = (b != 4);
      p2_din = d;
      @(negedge clk);
      check(p2_vld == (b != 4), "R10 pulse per beat", p2_vld, (b != 4));
      if (b != 4) check(p2_dout == d, "R10 data equals input", p2_dout, d);
      check(p2_sync == (b == 0), "R8 sync p2", p2_sync, (b == 0));
    end
    p2_wr = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule